// File: doc/BRIEF.md
# Instruction Fetch Address Translation Buffer

This block translates the virtual address of an instruction fetch into a physical address. It also decides whether the fetch may execute, based on the current privilege level. It holds a direct-mapped array of entries. Each entry pairs a match word with a translate word:

- **Match word:** carries the full virtual page number in its upper bits and a valid flag in bit 0.
- **Translate word:** carries the physical page frame in its upper bits and two execute-right bits, one for supervisor code and one for user code.

The lookup is purely combinational. A fetch address, a request strobe and a supervisor flag go in, and in the same cycle the block produces three outputs:

- the physical address;
- an execute flag;
- a two-bit outcome code. It tells apart a clean hit, a missing translation, an entry that holds the right page but is marked unusable, and a fetch that is refused for lack of execute rights.

Software, or a refill engine, loads entries through a clocked write port. The port takes an entry index and both words. A synchronous reset marks every entry unusable. The surrounding pipeline is expected to do the rest:

- raise a miss when the code says no-match or invalid;
- raise a page fault when the code says bad-address.

Top module: `itlb_lookup`

## Requirements
- R1: The virtual page number is `fetch_vaddr >> PAGE_BITS`. The entry consulted is the one whose index equals the low `$clog2(ENTRIES)` bits of that page number.
- R2: If the stored page number of the consulted entry (match word bits above `PAGE_BITS`) differs from the full virtual page number, `result` is 2'b01 (no-match). This holds whatever the valid flag says.
- R3: If the stored page number equals the virtual page number but bit 0 of the stored match word is 0, `result` is 2'b10 (invalid).
- R4: With `sup_mode` high, the execute right is translate-word bit `SUP_X_BIT` (default 6). With `sup_mode` low, it is bit `USR_X_BIT` (default 7).
- R5: On a valid hit with `fetch_req` high and no execute right, `result` is 2'b11 (bad-address). With `fetch_req` low, a valid hit always gives 2'b00.
- R6: When `result` is 2'b00 (match), `phys_addr` equals the translate-word bits above `PAGE_BITS`, followed by the low `PAGE_BITS` bits of `fetch_vaddr`.
- R7: `exec_ok` is high only on a valid hit whose selected execute right is 1. `phys_addr` is zero whenever `result` is not 2'b00.
- R8: When `wr_en` is high at a rising clock edge, entry `wr_idx` takes `wr_match` and `wr_xlate`, and lookups see them from the next cycle on. All other entries are left unchanged.
- R9: When `rst` is high at a rising edge, every entry's valid flag is cleared. After reset, no address gives match or bad-address until an entry is written valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_vaddr | input | ADDR_W | Virtual address of the fetch |
| fetch_req | input | 1 | High when the lookup is for an actual instruction fetch |
| sup_mode | input | 1 | High in supervisor mode, low in user mode |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | $clog2(ENTRIES) | Entry to write |
| wr_match | input | ADDR_W | Match word: page number above PAGE_BITS, valid in bit 0 |
| wr_xlate | input | ADDR_W | Translate word: frame above PAGE_BITS, execute rights at SUP_X_BIT and USR_X_BIT |
| phys_addr | output | ADDR_W | Translated physical address, zero unless result is match |
| exec_ok | output | 1 | Selected execute right of a valid hit |
| result | output | 2 | 00 match, 01 no-match, 10 invalid, 11 bad-address |

## Verification
The bench first loads every entry of a small configuration. It mixes valid and cleared flags and all four combinations of execute rights. One entry holds a page number whose low bits disagree with its own index. The bench then sweeps every virtual page number in both privilege modes, with the fetch strobe both high and low, at two page offsets. This sweep separates the following cases:

- a tag miss from a hit on an unusable entry;
- supervisor rights from user rights;
- a refused fetch from a plain non-fetch lookup;
- a frame splice that keeps the offset from one that does not.

Further checks rewrite a single entry and confirm its neighbours are unchanged. A final reset confirms that previously good pages fall back to invalid rather than to match.

// File: rtl/itlb_pkg.sv
package itlb_pkg;
  typedef enum logic [1:0] {
    RES_MATCH   = 2'b00,
    RES_NOMATCH = 2'b01,
    RES_INVALID = 2'b10,
    RES_BADADDR = 2'b11
  } itlb_res_e;
endpackage

// File: rtl/itlb_entry_store.sv
module itlb_entry_store #(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 13,
  parameter int ENTRIES   = 64,
  parameter int SUP_X_BIT = 6,
  parameter int USR_X_BIT = 7
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [$clog2(ENTRIES)-1:0]  wr_idx,
  input  logic [ADDR_W-1:0]           wr_match,
  input  logic [ADDR_W-1:0]           wr_xlate,
  input  logic [$clog2(ENTRIES)-1:0]  rd_idx,
  output logic [ADDR_W-PAGE_BITS-1:0] rd_tag,
  output logic                        rd_valid,
  output logic [ADDR_W-PAGE_BITS-1:0] rd_frame,
  output logic                        rd_sup_x,
  output logic                        rd_usr_x
);
  localparam int PN_W  = ADDR_W - PAGE_BITS;
  localparam int IDX_W = $clog2(ENTRIES);

  logic [PN_W-1:0]  tag_mem   [ENTRIES];
  logic [PN_W-1:0]  frame_mem [ENTRIES];
  logic [1:0]       xr_mem    [ENTRIES];
  logic [ENTRIES-1:0] valid_q;

  // RAM-style storage: no reset, single write port
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]   <= wr_match[ADDR_W-1:PAGE_BITS];
      frame_mem[wr_idx] <= wr_xlate[ADDR_W-1:PAGE_BITS];
      xr_mem[wr_idx]    <= {wr_xlate[USR_X_BIT], wr_xlate[SUP_X_BIT]};
    end
  end

  // Valid flags live in flops so that reset can clear them all at once
  for (genvar e = 0; e < ENTRIES; e++) begin : g_valid
    always_ff @(posedge clk) begin
      if (rst)
        valid_q[e] <= 1'b0;
      else if (wr_en && (wr_idx == IDX_W'(e)))
        valid_q[e] <= wr_match[0];
    end
  end

  always_comb begin
    rd_tag   = tag_mem[rd_idx];
    rd_frame = frame_mem[rd_idx];
    rd_sup_x = xr_mem[rd_idx][0];
    rd_usr_x = xr_mem[rd_idx][1];
    rd_valid = valid_q[rd_idx];
  end

  // R9: the cycle after a reset edge, no entry is usable
  a_r9_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (valid_q == '0));

  // R8: a write lands its valid flag in the addressed entry
  a_r8_write_valid: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !$past(rst)) |=> (valid_q[$past(wr_idx)] == $past(wr_match[0])));
endmodule

// File: rtl/itlb_perm.sv
module itlb_perm (
  input  logic sup_mode,
  input  logic sup_x,
  input  logic usr_x,
  output logic x_right
);
  always_comb x_right = sup_mode ? sup_x : usr_x;
endmodule

// File: rtl/itlb_resolve.sv
module itlb_resolve
  import itlb_pkg::*;
#(
  parameter int PN_W = 19
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PN_W-1:0] vpn,
  input  logic [PN_W-1:0] stored_tag,
  input  logic            entry_valid,
  input  logic            x_right,
  input  logic            fetch_req,
  output itlb_res_e       code,
  output logic            exec_ok
);
  logic tag_hit;

  always_comb begin
    tag_hit = (stored_tag == vpn);
    exec_ok = 1'b0;
    // Miss takes priority over the valid check
    if (!tag_hit)
      code = RES_NOMATCH;
    else if (!entry_valid)
      code = RES_INVALID;
    else if (fetch_req && !x_right)
      code = RES_BADADDR;
    else begin
      code    = RES_MATCH;
      exec_ok = x_right;
    end
  end

  // R3: invalid only reported for a tag hit on an unusable entry
  a_r3_invalid_source: assert property (@(posedge clk) disable iff (rst)
    (code == RES_INVALID) |-> ((stored_tag == vpn) && !entry_valid));

  // R2: a mismatching tag can never yield anything but no-match
  a_r2_mismatch_wins: assert property (@(posedge clk) disable iff (rst)
    (stored_tag != vpn) |-> (code == RES_NOMATCH && !exec_ok));
endmodule

// File: rtl/itlb_lookup.sv
module itlb_lookup
  import itlb_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 13,
  parameter int ENTRIES   = 64,
  parameter int SUP_X_BIT = 6,
  parameter int USR_X_BIT = 7
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          fetch_vaddr,
  input  logic                       fetch_req,
  input  logic                       sup_mode,
  input  logic                       wr_en,
  input  logic [$clog2(ENTRIES)-1:0] wr_idx,
  input  logic [ADDR_W-1:0]          wr_match,
  input  logic [ADDR_W-1:0]          wr_xlate,
  output logic [ADDR_W-1:0]          phys_addr,
  output logic                       exec_ok,
  output logic [1:0]                 result
);
  localparam int PN_W  = ADDR_W - PAGE_BITS;
  localparam int IDX_W = $clog2(ENTRIES);

  logic [PN_W-1:0]  vpn;
  logic [IDX_W-1:0] idx;
  logic [PN_W-1:0]  st_tag, st_frame;
  logic             st_valid, st_sx, st_ux, x_right;
  itlb_res_e        code;

  always_comb begin
    vpn = fetch_vaddr[ADDR_W-1:PAGE_BITS];
    idx = vpn[IDX_W-1:0];
  end

  itlb_entry_store #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .ENTRIES(ENTRIES),
    .SUP_X_BIT(SUP_X_BIT), .USR_X_BIT(USR_X_BIT)
  ) u_store (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_match(wr_match), .wr_xlate(wr_xlate),
    .rd_idx(idx), .rd_tag(st_tag), .rd_valid(st_valid),
    .rd_frame(st_frame), .rd_sup_x(st_sx), .rd_usr_x(st_ux)
  );

  itlb_perm u_perm (
    .sup_mode(sup_mode), .sup_x(st_sx), .usr_x(st_ux), .x_right(x_right)
  );

  itlb_resolve #(.PN_W(PN_W)) u_resolve (
    .clk(clk), .rst(rst),
    .vpn(vpn), .stored_tag(st_tag), .entry_valid(st_valid),
    .x_right(x_right), .fetch_req(fetch_req),
    .code(code), .exec_ok(exec_ok)
  );

  always_comb begin
    result    = code;
    phys_addr = (code == RES_MATCH) ?
                {st_frame, fetch_vaddr[PAGE_BITS-1:0]} : '0;
  end

  // R6: a match keeps the page offset of the fetch address
  a_r6_offset_kept: assert property (@(posedge clk) disable iff (rst)
    (result == 2'b00) |-> (phys_addr[PAGE_BITS-1:0] == fetch_vaddr[PAGE_BITS-1:0]));

  // R5: a refused fetch is a real fetch without execute right
  a_r5_bad_needs_fetch: assert property (@(posedge clk) disable iff (rst)
    (result == 2'b11) |-> (fetch_req && !exec_ok));

  // R4: a granted fetch carries execute right
  a_r4_fetch_grant: assert property (@(posedge clk) disable iff (rst)
    (result == 2'b00 && fetch_req) |-> exec_ok);

  // R7: outputs quiet outside a match
  a_r7_quiet_outputs: assert property (@(posedge clk) disable iff (rst)
    (result != 2'b00) |-> (phys_addr == '0 && !exec_ok));
endmodule

// File: tb/tb_itlb_lookup.sv
module tb_itlb_lookup;
  localparam int AW = 20, PB = 13, NE = 8, SX = 6, UX = 7;
  localparam int PNW = AW - PB, IW = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic [AW-1:0] fetch_vaddr = '0, wr_match = '0, wr_xlate = '0;
  logic fetch_req = 1'b0, sup_mode = 1'b0, wr_en = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [AW-1:0] phys_addr;
  logic exec_ok;
  logic [1:0] result;

  int checks = 0, fails = 0;
  logic [PNW-1:0] m_tag [NE];
  logic [PNW-1:0] m_frame [NE];
  logic m_valid [NE], m_sx [NE], m_ux [NE];

  always #4 clk = ~clk;

  itlb_lookup #(.ADDR_W(AW), .PAGE_BITS(PB), .ENTRIES(NE),
                .SUP_X_BIT(SX), .USR_X_BIT(UX)) dut (
    .clk(clk), .rst(rst), .fetch_vaddr(fetch_vaddr), .fetch_req(fetch_req),
    .sup_mode(sup_mode), .wr_en(wr_en), .wr_idx(wr_idx), .wr_match(wr_match),
    .wr_xlate(wr_xlate), .phys_addr(phys_addr), .exec_ok(exec_ok), .result(result));

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic put(input int i, input logic [PNW-1:0] tag, input logic v,
                     input logic [PNW-1:0] fr, input logic sx, input logic ux);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IW'(i);
    wr_match = {tag, {(PB-1){1'b0}}, v};
    wr_xlate = '0;
    wr_xlate[AW-1:PB] = fr; wr_xlate[SX] = sx; wr_xlate[UX] = ux;
    @(negedge clk);
    wr_en = 1'b0;
    m_tag[i] = tag; m_valid[i] = v; m_frame[i] = fr; m_sx[i] = sx; m_ux[i] = ux;
  endtask

  task automatic probe(input logic [PNW-1:0] vpn, input logic [PB-1:0] off,
                       input logic sm, input logic fr, input string req);
    logic [1:0] e_res; logic e_x; logic [AW-1:0] e_pa; int k; logic rt;
    fetch_vaddr = {vpn, off}; sup_mode = sm; fetch_req = fr;
    #1;
    k = int'(vpn[IW-1:0]);                       // R1 index selection
    e_res = 2'b00; e_x = 1'b0; e_pa = '0;
    rt = sm ? m_sx[k] : m_ux[k];
    if (m_tag[k] != vpn) e_res = 2'b01;
    else if (!m_valid[k]) e_res = 2'b10;
    else if (fr && !rt) e_res = 2'b11;
    else begin e_x = rt; e_pa = {m_frame[k], off}; end
    checks++;
    if (result !== e_res || exec_ok !== e_x || phys_addr !== e_pa) begin
      fails++;
      $display("FAIL %s vpn=%0d sup=%0b fetch=%0b: actual res=%b x=%b pa=%h expected res=%b x=%b pa=%h",
               req, vpn, sm, fr, result, exec_ok, phys_addr, e_res, e_x, e_pa);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9: after reset nothing matches or is refused
    for (int v = 0; v < (1 << PNW); v++) begin
      fetch_vaddr = {PNW'(v), 13'h0a5}; fetch_req = 1'b1; sup_mode = v[0];
      #1;
      checks++;
      if (result == 2'b00 || result == 2'b11 || exec_ok !== 1'b0) begin
        fails++;
        $display("FAIL R9 reset vpn=%0d: actual res=%b x=%b expected res=01/10 x=0",
                 v, result, exec_ok);
      end
    end
    // R8 loads; entry 6 holds a tag whose low bits disagree with its index (R1/R2)
    for (int i = 0; i < NE; i++) begin
      logic [PNW-1:0] tg;
      tg = {4'((i*5 + 3) & 15), 3'(i)};
      if (i == 6) tg[2:0] = 3'd1;
      put(i, tg, (i != 2 && i != 5), PNW'((i*37 + 11) & 127), i[0], i[1]);
    end
    // R2 R3 R4 R5 R6 R7 exhaustive sweep
    for (int v = 0; v < (1 << PNW); v++)
      for (int m = 0; m < 4; m++) begin
        probe(PNW'(v), 13'h0000, m[0], m[1], "R2/R3/R4/R5/R6/R7");
        probe(PNW'(v), 13'h1fff, m[0], m[1], "R2/R3/R4/R5/R6/R7");
      end
    // R8: rewrite entry 3, neighbour entry 4 untouched
    put(3, m_tag[3], 1'b1, 7'h55, 1'b1, 1'b1);
    probe(m_tag[3], 13'h0123, 1'b0, 1'b1, "R8 rewrite");
    probe(m_tag[3], 13'h0123, 1'b1, 1'b1, "R8 rewrite");
    probe(m_tag[4], 13'h0777, 1'b1, 1'b1, "R8 neighbour");
    probe(m_tag[4], 13'h0777, 1'b0, 1'b0, "R8 neighbour");
    // R8: writing valid=0 turns a match into invalid
    put(1, m_tag[1], 1'b0, m_frame[1], 1'b1, 1'b1);
    probe(m_tag[1], 13'h0001, 1'b1, 1'b1, "R8 R3 clear");
    // R9: reset again, known good pages become invalid
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < NE; i++) m_valid[i] = 1'b0;
    probe(m_tag[3], 13'h0040, 1'b1, 1'b1, "R9 re-reset");
    probe(m_tag[0], 13'h0040, 1'b0, 1'b0, "R9 re-reset");
    probe(m_tag[7], 13'h1040, 1'b1, 1'b0, "R9 re-reset");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule